// File: doc/BRIEF.md
# Dual-Ratio Clock Sync Pulse Generator

The block takes one fast reference clock and produces two slower clocks, `clk_a` and `clk_c`. Each comes from its own even divider, so the two rates need not be integer multiples of each other. Both divided clocks rise together at a regular interval. That interval is the least common multiple (L) of the two divide ratios, counted in reference cycles. Just before each shared rising edge, the block drives an active-low marker, `sync_n`. Logic downstream can use this marker to tell which of the slower edges is the aligned one.

The two ratios are captured while the synchronous reset is held. After reset is released, a small state machine checks the captured ratios. If they are valid, it works out L by stepping two running multiples until they meet. It then starts a master phase counter that wraps at L. The clocks, the marker and the valid flag are all registered on the reference clock, so every output edge lands on the same reference edge as its neighbours.

The control state machine has four states:
- `ST_LATCH` is forced while reset is held and captures the ratios. It goes to `ST_SEARCH` if both ratios are valid and to `ST_HALT` if either is not.
- `ST_SEARCH` advances the smaller running multiple each cycle. It goes to `ST_RUN` once the two multiples are equal.
- `ST_RUN` counts the phase modulo L and has no exit except reset.
- `ST_HALT` holds every output idle until the next reset.

Top module: `dual_ratio_sync`

## Requirements
- R1: `ratio_a` and `ratio_c` are sampled only while `rst` is high. Changing them after reset is released has no effect on any output until the next reset.
- R2: A ratio is valid only if it is even and lies between 2 and 40 inclusive. If either captured ratio is invalid, then after release `cfg_ok` stays 0, both clocks stay 0 and `sync_n` stays 1 until the next reset.
- R3: While `rst` is high, the outputs are `clk_a`=0, `clk_c`=0, `sync_n`=1 and `cfg_ok`=0.
- R4: With valid ratios A and C, `cfg_ok` rises on edge 1 and then stays high. Edge 1 is the first rising reference edge sampled with `rst` low. Both clocks stay 0 and `sync_n` stays 1 until edge 1+L/A+L/C, where L = lcm(A,C). On that edge both clocks rise together.
- R5: Once running, `clk_a` repeats every A reference cycles and is high for the first A/2 cycles of each period. `clk_c` does the same with C.
- R6: The rising edges of `clk_a` and `clk_c` coincide exactly every L reference cycles.
- R7: `sync_n` is low for exactly the min(A,C) reference cycles before each coincident rising edge and is high at all other times. It returns high on the same reference edge on which both clocks rise. When A equals C, `sync_n` therefore stays low from the first pulse onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock; every output changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; ratios are captured while it is high |
| ratio_a | input | 6 | Divide ratio for `clk_a` |
| ratio_c | input | 6 | Divide ratio for `clk_c` |
| clk_a | output | 1 | First divided clock, 50% duty |
| clk_c | output | 1 | Second divided clock, 50% duty |
| sync_n | output | 1 | Active-low marker before each shared rising edge |
| cfg_ok | output | 1 | High when the captured ratios are valid |

## Verification
The assertions assume the following about the inputs:
- `rst` is held for at least one reference edge before each run.
- The ratio inputs are stable on the last reset edge.

Under these assumptions, the period, high-time and marker-width counters in the checker all start from the idle reset values. The bench changes ratios only at negative edges and only while reset is held. After release, it drives the inputs to deliberately unrelated values, including odd ones, to show that they are ignored. It applies every listed ratio pair, one ratio swept across all even values against several partners, and a few invalid captures, each after a fresh reset.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    // Control states of the ratio sync generator
    typedef enum logic [1:0] {
        ST_LATCH  = 2'd0,   // reset held: capture ratios
        ST_SEARCH = 2'd1,   // stepping running multiples toward the LCM
        ST_RUN    = 2'd2,   // phase counter active
        ST_HALT   = 2'd3    // invalid ratio captured: outputs idle
    } rsp_state_t;

endpackage

// File: rtl/rsp_lcm_engine.sv
// Iterative least-common-multiple finder: two running multiples, the
// smaller one advances by its own ratio each step until they are equal.
module rsp_lcm_engine #(
    parameter int RATIO_W = 6,
    parameter int CNT_W   = 2 * RATIO_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  logic [RATIO_W-1:0] ratio_a,
    input  logic [RATIO_W-1:0] ratio_c,
    output logic               done,
    output logic [CNT_W-1:0]   lcm
);

    logic [CNT_W-1:0] mult_a;
    logic [CNT_W-1:0] mult_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            mult_a <= '0;
            mult_c <= '0;
        end else if (load) begin
            mult_a <= CNT_W'(ratio_a);
            mult_c <= CNT_W'(ratio_c);
        end else if (step && !done) begin
            if (mult_a < mult_c) begin
                mult_a <= mult_a + CNT_W'(ratio_a);
            end else begin
                mult_c <= mult_c + CNT_W'(ratio_c);
            end
        end
    end

    assign done = (mult_a == mult_c);
    assign lcm  = mult_a;

endmodule

// File: rtl/rsp_clk_div.sv
// Even divider with a registered 50% output; its phase restarts at zero
// whenever run is low, so all dividers start aligned with the master count.
module rsp_clk_div #(
    parameter int RATIO_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [RATIO_W-1:0] ratio,
    output logic               clk_out
);

    logic [RATIO_W-1:0] phase;
    logic [RATIO_W-1:0] half;
    logic               wrap;

    assign half = ratio >> 1;
    assign wrap = (phase == ratio - RATIO_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase   <= '0;
            clk_out <= 1'b0;
        end else begin
            clk_out <= (phase < half);
            phase   <= wrap ? '0 : phase + RATIO_W'(1);
        end
    end

endmodule

// File: rtl/dual_ratio_sync.sv
module dual_ratio_sync #(
    parameter int RATIO_W   = 6,
    parameter int RATIO_MIN = 2,
    parameter int RATIO_MAX = 40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio_a,
    input  logic [RATIO_W-1:0] ratio_c,
    output logic               clk_a,
    output logic               clk_c,
    output logic               sync_n,
    output logic               cfg_ok
);
    import rsp_pkg::*;

    localparam int CNT_W  = 2 * RATIO_W;
    localparam int N_DIV  = 2;

    rsp_state_t         state;
    rsp_state_t         state_nxt;

    logic [RATIO_W-1:0] ra_q;
    logic [RATIO_W-1:0] rc_q;
    logic [RATIO_W-1:0] rmin_q;
    logic [CNT_W-1:0]   lcm_q;
    logic [CNT_W-1:0]   phase_cnt;
    logic [CNT_W-1:0]   pulse_start;
    logic               sync_q;
    logic               both_ok;
    logic               lcm_done;
    logic [CNT_W-1:0]   lcm_val;
    logic               running;
    logic [RATIO_W-1:0] div_ratio [N_DIV];
    logic [N_DIV-1:0]   div_out;

    function automatic logic ratio_ok(input logic [RATIO_W-1:0] r);
        return (r[0] == 1'b0)
            && (r >= RATIO_W'(RATIO_MIN))
            && (r <= RATIO_W'(RATIO_MAX));
    endfunction

    assign both_ok = ratio_ok(ra_q) && ratio_ok(rc_q);
    assign running = (state == ST_RUN);

    // Ratio capture: only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            ra_q   <= ratio_a;
            rc_q   <= ratio_c;
            rmin_q <= (ratio_a < ratio_c) ? ratio_a : ratio_c;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_LATCH;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_LATCH:  state_nxt = both_ok ? ST_SEARCH : ST_HALT;
            ST_SEARCH: state_nxt = lcm_done ? ST_RUN : ST_SEARCH;
            ST_RUN:    state_nxt = ST_RUN;
            ST_HALT:   state_nxt = ST_HALT;
        endcase
    end

    rsp_lcm_engine #(
        .RATIO_W (RATIO_W),
        .CNT_W   (CNT_W)
    ) i_lcm (
        .clk     (clk),
        .rst     (rst),
        .load    (state == ST_LATCH),
        .step    (state == ST_SEARCH),
        .ratio_a (ra_q),
        .ratio_c (rc_q),
        .done    (lcm_done),
        .lcm     (lcm_val)
    );

    // LCM capture and master phase counter
    always_ff @(posedge clk) begin
        if (rst) begin
            lcm_q     <= '0;
            phase_cnt <= '0;
        end else begin
            if (state == ST_SEARCH && lcm_done) begin
                lcm_q <= lcm_val;
            end
            if (!running) begin
                phase_cnt <= '0;
            end else if (phase_cnt == lcm_q - CNT_W'(1)) begin
                phase_cnt <= '0;
            end else begin
                phase_cnt <= phase_cnt + CNT_W'(1);
            end
        end
    end

    // Divided clocks
    assign div_ratio[0] = ra_q;
    assign div_ratio[1] = rc_q;

    for (genvar g = 0; g < N_DIV; g++) begin : g_div
        rsp_clk_div #(
            .RATIO_W (RATIO_W)
        ) i_div (
            .clk     (clk),
            .rst     (rst),
            .run     (running),
            .ratio   (div_ratio[g]),
            .clk_out (div_out[g])
        );
    end

    // Sync marker: low over the last min-ratio counts before the wrap
    assign pulse_start = lcm_q - CNT_W'(rmin_q);

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            sync_q <= 1'b1;
        end else begin
            sync_q <= !(phase_cnt >= pulse_start);
        end
    end

    // Outputs
    always_comb begin
        clk_a  = div_out[0];
        clk_c  = div_out[1];
        sync_n = sync_q;
        cfg_ok = (state == ST_SEARCH) || (state == ST_RUN);
    end

endmodule

// File: rtl/rsp_checker.sv
module rsp_checker #(
    parameter int RATIO_W = 6,
    parameter int CNT_W   = 2 * RATIO_W
) (
    input logic               clk,
    input logic               rst,
    input logic               clk_a,
    input logic               clk_c,
    input logic               sync_n,
    input logic               cfg_ok,
    input logic [RATIO_W-1:0] ra_q,
    input logic [RATIO_W-1:0] rc_q,
    input logic [CNT_W-1:0]   lcm_q
);

    logic               prev_a, prev_c, prev_s;
    logic               seen_a, seen_c, seen_co;
    logic [CNT_W-1:0]   gap_a, gap_c, gap_co, hi_a, hi_c, lo_s;
    logic [RATIO_W-1:0] rmin;
    logic               rise_a, rise_c, fall_s;

    assign rmin   = (ra_q < rc_q) ? ra_q : rc_q;
    assign rise_a = clk_a && !prev_a;
    assign rise_c = clk_c && !prev_c;
    assign fall_s = !sync_n && prev_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_a  <= 1'b0;
            prev_c  <= 1'b0;
            prev_s  <= 1'b1;
            seen_a  <= 1'b0;
            seen_c  <= 1'b0;
            seen_co <= 1'b0;
            gap_a   <= '0;
            gap_c   <= '0;
            gap_co  <= '0;
            hi_a    <= '0;
            hi_c    <= '0;
            lo_s    <= '0;
        end else begin
            prev_a <= clk_a;
            prev_c <= clk_c;
            prev_s <= sync_n;
            if (rise_a) seen_a <= 1'b1;
            if (rise_c) seen_c <= 1'b1;
            if (rise_a && rise_c) seen_co <= 1'b1;
            gap_a  <= rise_a ? CNT_W'(1) : ((gap_a == '1) ? gap_a : gap_a + CNT_W'(1));
            gap_c  <= rise_c ? CNT_W'(1) : ((gap_c == '1) ? gap_c : gap_c + CNT_W'(1));
            gap_co <= (rise_a && rise_c) ? CNT_W'(1)
                    : ((gap_co == '1) ? gap_co : gap_co + CNT_W'(1));
            if (rise_a) hi_a <= CNT_W'(1);
            else if (clk_a && hi_a != '1) hi_a <= hi_a + CNT_W'(1);
            if (rise_c) hi_c <= CNT_W'(1);
            else if (clk_c && hi_c != '1) hi_c <= hi_c + CNT_W'(1);
            if (fall_s) lo_s <= CNT_W'(1);
            else if (!sync_n && lo_s != '1) lo_s <= lo_s + CNT_W'(1);
        end
    end

    p_idle_invalid_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg_ok |-> (!clk_a && !clk_c && sync_n));

    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_ok |=> cfg_ok);

    p_period_a_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(clk_a) && seen_a) |-> (gap_a == CNT_W'(ra_q)));

    p_high_a_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_a) |-> (hi_a == CNT_W'(ra_q >> 1)));

    p_period_c_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(clk_c) && seen_c) |-> (gap_c == CNT_W'(rc_q)));

    p_high_c_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_c) |-> (hi_c == CNT_W'(rc_q >> 1)));

    p_coinc_period_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(clk_a) && $rose(clk_c) && seen_co) |-> (gap_co == lcm_q));

    p_sync_width_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_n) |-> (lo_s == CNT_W'(rmin)));

    p_sync_at_coinc_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_n) |-> ($rose(clk_a) && $rose(clk_c)));

endmodule

bind dual_ratio_sync rsp_checker #(
    .RATIO_W (RATIO_W),
    .CNT_W   (CNT_W)
) i_rsp_checker (
    .clk    (clk),
    .rst    (rst),
    .clk_a  (clk_a),
    .clk_c  (clk_c),
    .sync_n (sync_n),
    .cfg_ok (cfg_ok),
    .ra_q   (ra_q),
    .rc_q   (rc_q),
    .lcm_q  (lcm_q)
);

// File: tb/test_dual_ratio_sync.sv
module test_dual_ratio_sync;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] ratio_a = 6'd2;
    logic [5:0] ratio_c = 6'd2;
    logic       clk_a, clk_c, sync_n, cfg_ok;

    int n_checks = 0;
    int n_errors = 0;

    dual_ratio_sync i_dual_ratio_sync (
        .clk     (clk),
        .rst     (rst),
        .ratio_a (ratio_a),
        .ratio_c (ratio_c),
        .clk_a   (clk_a),
        .clk_c   (clk_c),
        .sync_n  (sync_n),
        .cfg_ok  (cfg_ok)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int gcd(input int x, input int y);
        int p = x;
        int q = y;
        while (q != 0) begin
            int t = p % q;
            p = q;
            q = t;
        end
        return p;
    endfunction

    // observed vector: {clk_a, clk_c, sync_n, cfg_ok}
    task automatic check(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {clk_a, clk_c, sync_n, cfg_ok};
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s at %0t: {clk_a,clk_c,sync_n,cfg_ok} actual %b expected %b",
                     tag, $time, act, exp);
        end
    endtask

    task automatic apply_reset(input int a, input int c);
        @(negedge clk);
        rst     = 1'b1;
        ratio_a = 6'(a);
        ratio_c = 6'(c);
        repeat (3) @(negedge clk);
        check("R3 reset state", 4'b0010);
    endtask

    task automatic run_pair(input int a, input int c, input int periods);
        int l, first, rmin, n;
        apply_reset(a, c);
        rst     = 1'b0;
        ratio_a = 6'd3;     // R1: post-reset changes must be ignored
        ratio_c = 6'd61;
        l     = (a / gcd(a, c)) * c;
        first = 1 + l / a + l / c;
        rmin  = (a < c) ? a : c;
        for (int idx = 1; idx < first; idx++) begin
            @(negedge clk);
            check("R4 idle before start", 4'b0011);
        end
        n = periods * l + rmin;
        for (int k = 0; k < n; k++) begin
            logic ea, ec, es;
            int   j;
            @(negedge clk);
            ea = ((k % a) < (a / 2));
            ec = ((k % c) < (c / 2));
            j  = k + 1;
            while ((j % a) != 0 || (j % c) != 0) j++;
            es = !((j - k) <= rmin);
            check("R1 R5 R6 R7 running pattern", {ea, ec, es, 1'b1});
        end
    endtask

    task automatic run_bad(input int a, input int c);
        apply_reset(a, c);
        rst     = 1'b0;
        ratio_a = 6'd4;     // R1: valid values after release stay ignored
        ratio_c = 6'd6;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check("R2 invalid ratio idle", 4'b0010);
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        // listed ratio relationships
        run_pair(2, 2, 3);
        run_pair(6, 2, 2);
        run_pair(4, 6, 2);
        run_pair(2, 8, 2);
        run_pair(6, 8, 2);
        run_pair(12, 2, 2);
        run_pair(10, 10, 2);
        run_pair(40, 38, 2);
        run_pair(2, 40, 2);
        run_pair(14, 10, 2);
        // invalid captures
        run_bad(3, 6);
        run_bad(0, 4);
        run_bad(42, 2);
        run_bad(6, 63);
        // sweep
        for (int a = 2; a <= 40; a += 2) begin
            for (int c = 2; c <= 40; c += 6) begin
                run_pair(a, c, 1);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule